// File: doc/BRIEF.md
# Phase-Shift Step Sequencer

This block sits between a small register bus and the dynamic phase-adjust port of a PLL. Software loads a 16-bit step count, then writes a command word whose self-clearing go bit starts a run. The block turns that single command into a chain of single phase steps. It pulses the PLL step-enable for one cycle, waits for the PLL's done pulse, and then issues the next step, until the count is used up. Direction is chosen per run. About 3360 steps make up one full clock period.

The same command word selects the PLL input clock. Writing 0 selects the acquisition clock and writing 1 selects an independent clock. A self-clearing reset bit aborts any run, holds the PLL in reset for a fixed number of cycles and returns the phase to its default. A status word shows whether a run is in progress and whether the PLL reports lock. A signed step accumulator is brought out as a port so that the net phase offset can be observed.

Top module: `phase_step_ctrl`

## Requirements
- R1: After the synchronous reset, pll_step, pll_rst, pll_dir, pll_clksel and the busy flag are 0, phase_acc is 0, and the command and count registers read back 0.
- R2: A go command with count N > 0 produces exactly N pll_step pulses, each one cycle wide. The first pulse is high in the cycle after the bus write. Each later pulse is high in the cycle after the pll_done pulse that completes the previous step, and no step is issued while a done is outstanding.
- R3: Command bit 1 sets the direction (0 forward, 1 backward). pll_dir carries it, unchanged, for the whole run, and each accepted done moves phase_acc by +1 forward or -1 backward.
- R4: Command bit 2 drives pll_clksel (0 acquisition clock, 1 independent clock). It reads back at bit 2 of the command register at address 0.
- R5: Command bit 0 (go) and bit 3 (reset) always read back as 0. Bit 1 reads back the written direction.
- R6: The count register at address 1 holds 16 bits and reads back the low 16 bits of the written data.
- R7: Status register at address 2: bit 0 is busy and bit 1 is the PLL lock input. Busy rises in the cycle after an accepted go and falls in the cycle after the final done. Reads return data one cycle after the read strobe.
- R8: A go command with a count of 0 issues no step and leaves busy low.
- R9: A go command written while busy is ignored, so the run completes with its original count and direction.
- R10: Command bit 3 aborts any run, clears busy and returns phase_acc to 0 in the cycle after the write. It drives pll_rst high for exactly RST_CYCLES consecutive cycles and takes priority over a go bit in the same write.
- R11: A go command is refused while pll_rst is high or pll_locked is low.
- R12: A pll_done pulse that arrives while no step is outstanding (idle, or in the same cycle as the step-enable) leaves phase_acc and busy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address: 0 command, 1 count, 2 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| pll_step | output | 1 | One-cycle phase step enable |
| pll_dir | output | 1 | Step direction, 1 = backward |
| pll_done | input | 1 | One-cycle step-complete pulse from the PLL |
| pll_rst | output | 1 | PLL reset |
| pll_clksel | output | 1 | PLL input clock select |
| pll_locked | input | 1 | PLL lock indication |
| phase_acc | output | ACC_W | Signed net step count since the last reset |

## Verification
Every result is registered once, so it is due one cycle after the edge that samples its cause. After a bus write, pll_step, pll_rst and busy change in the next cycle. After a done pulse, phase_acc and the next step change in the next cycle. Read data is valid one cycle after the strobe. The bench drives all inputs and samples all outputs on the falling edge. Each check is taken at the first falling edge after the rising edge that should produce the result, and the handshake test holds back pll_done by hand to show that no step comes early.

// File: rtl/ps_pkg.sv
package ps_pkg;
  // Register word addresses
  localparam int unsigned ADR_CMD  = 0;
  localparam int unsigned ADR_CNT  = 1;
  localparam int unsigned ADR_STAT = 2;

  // Command word bits
  localparam int unsigned CB_GO  = 0;
  localparam int unsigned CB_DIR = 1;
  localparam int unsigned CB_SEL = 2;
  localparam int unsigned CB_RST = 3;

  // Status word bits
  localparam int unsigned SB_BUSY = 0;
  localparam int unsigned SB_LOCK = 1;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } step_state_t;
endpackage

// File: rtl/ps_regs.sv
module ps_regs #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              locked,
  output logic              go_pulse,
  output logic              rst_pulse,
  output logic              go_dir,
  output logic              clksel_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [DATA_W-1:0] rdata
);
  import ps_pkg::*;

  logic              cmd_wr;
  logic              cnt_wr;
  logic              dir_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    cmd_wr    = wr && (addr == ADDR_W'(ADR_CMD));
    cnt_wr    = wr && (addr == ADDR_W'(ADR_CNT));
    go_pulse  = cmd_wr && wdata[CB_GO];
    rst_pulse = cmd_wr && wdata[CB_RST];
    go_dir    = wdata[CB_DIR];
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADR_CMD)) begin
      rd_mux[CB_DIR] = dir_q;
      rd_mux[CB_SEL] = clksel_q;
    end else if (addr == ADDR_W'(ADR_CNT)) begin
      rd_mux[CNT_W-1:0] = count_q;
    end else if (addr == ADDR_W'(ADR_STAT)) begin
      rd_mux[SB_BUSY] = busy;
      rd_mux[SB_LOCK] = locked;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= 1'b0;
      clksel_q <= 1'b0;
      count_q  <= '0;
      rdata    <= '0;
    end else begin
      if (cmd_wr) begin
        dir_q    <= wdata[CB_DIR];
        clksel_q <= wdata[CB_SEL];
      end
      if (cnt_wr) count_q <= wdata[CNT_W-1:0];
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ps_reset_seq.sv
module ps_reset_seq #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pll_rst
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pll_rst <= 1'b0;
    end else if (trig) begin
      cnt_q   <= CW'(RST_CYCLES - 1);
      pll_rst <= 1'b1;
    end else if (pll_rst) begin
      if (cnt_q == '0) pll_rst <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ps_stepper.sv
module ps_stepper #(
  parameter int CNT_W = 16,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic                    go_dir,
  input  logic                    go_ok,
  input  logic [CNT_W-1:0]        count,
  input  logic                    abort,
  input  logic                    done,
  output logic                    step,
  output logic                    dir,
  output logic                    busy,
  output logic signed [ACC_W-1:0] acc
);
  import ps_pkg::*;

  localparam logic signed [ACC_W-1:0] ACC_ONE = ACC_W'(1);
  localparam logic [CNT_W-1:0]        LAST    = CNT_W'(1);

  step_state_t      state_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      step    <= 1'b0;
      dir     <= 1'b0;
      busy    <= 1'b0;
      acc     <= '0;
    end else if (abort) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      step    <= 1'b0;
      busy    <= 1'b0;
      acc     <= '0;
    end else begin
      step <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (go && go_ok && (count != '0)) begin
            state_q <= ST_WAIT;
            left_q  <= count;
            dir     <= go_dir;
            busy    <= 1'b1;
            step    <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (done && !step) begin
            acc <= dir ? (acc - ACC_ONE) : (acc + ACC_ONE);
            if (left_q == LAST) begin
              state_q <= ST_IDLE;
              left_q  <= '0;
              busy    <= 1'b0;
            end else begin
              left_q <= left_q - 1'b1;
              step   <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int ACC_W      = 20,
  parameter int RST_CYCLES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    pll_step,
  output logic                    pll_dir,
  input  logic                    pll_done,
  output logic                    pll_rst,
  output logic                    pll_clksel,
  input  logic                    pll_locked,
  output logic signed [ACC_W-1:0] phase_acc
);
  logic             go_pulse;
  logic             rst_pulse;
  logic             go_dir;
  logic             busy_w;
  logic             go_ok;
  logic [CNT_W-1:0] count_w;

  ps_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .busy     (busy_w),
    .locked   (pll_locked),
    .go_pulse (go_pulse),
    .rst_pulse(rst_pulse),
    .go_dir   (go_dir),
    .clksel_q (pll_clksel),
    .count_q  (count_w),
    .rdata    (bus_rdata)
  );

  ps_reset_seq #(
    .RST_CYCLES(RST_CYCLES)
  ) u_rstseq (
    .clk    (clk),
    .rst    (rst),
    .trig   (rst_pulse),
    .pll_rst(pll_rst)
  );

  assign go_ok = pll_locked && !pll_rst;

  ps_stepper #(
    .CNT_W(CNT_W),
    .ACC_W(ACC_W)
  ) u_stepper (
    .clk   (clk),
    .rst   (rst),
    .go    (go_pulse),
    .go_dir(go_dir),
    .go_ok (go_ok),
    .count (count_w),
    .abort (rst_pulse),
    .done  (pll_done),
    .step  (pll_step),
    .dir   (pll_dir),
    .busy  (busy_w),
    .acc   (phase_acc)
  );
endmodule

// File: rtl/ps_step_chk.sv
module ps_step_chk #(
  parameter int ACC_W = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    pll_step,
  input logic                    pll_dir,
  input logic                    pll_done,
  input logic                    pll_rst,
  input logic                    pll_locked,
  input logic                    busy,
  input logic signed [ACC_W-1:0] phase_acc
);
  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pll_step |=> !pll_step);  // R2
  AST_STEP_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    pll_step |-> busy);  // R2
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(pll_dir));  // R3
  AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    pll_rst |-> (!busy && !pll_step));  // R10
  AST_GO_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(pll_locked) && !$past(pll_rst)));  // R11
  AST_ACC_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    ((phase_acc != $past(phase_acc)) && (phase_acc != '0)) |-> $past(pll_done));  // R12
endmodule

bind phase_step_ctrl ps_step_chk #(.ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pll_step  (pll_step),
  .pll_dir   (pll_dir),
  .pll_done  (pll_done),
  .pll_rst   (pll_rst),
  .pll_locked(pll_locked),
  .busy      (busy_w),
  .phase_acc (phase_acc)
);

// File: tb/tb_phase_step_ctrl.sv
module tb_phase_step_ctrl;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 20;
  localparam int RSTC   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              pll_step, pll_dir, pll_rst, pll_clksel, pll_done;
  logic              pll_locked = 1'b0;
  logic signed [ACC_W-1:0] phase_acc;

  logic model_done = 1'b0;
  logic man_done   = 1'b0;
  logic auto_done  = 1'b1;
  int   dly = 0;
  int   lock_cnt = 0;
  int   steps_seen = 0;
  int   rst_hi = 0;
  int   tests = 0;
  int   fails = 0;
  int   exp_acc = 0;

  assign pll_done = model_done | man_done;

  always #10 clk = ~clk;

  phase_step_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_W(ACC_W), .RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_step(pll_step), .pll_dir(pll_dir),
    .pll_done(pll_done), .pll_rst(pll_rst), .pll_clksel(pll_clksel),
    .pll_locked(pll_locked), .phase_acc(phase_acc)
  );

  // PLL model: done three cycles after each step; lock lost in reset
  always @(posedge clk) begin
    model_done <= 1'b0;
    if (pll_step) dly <= 3;
    else if (dly > 1) dly <= dly - 1;
    else if (dly == 1) begin
      dly <= 0;
      if (auto_done) model_done <= 1'b1;
    end
    if (rst || pll_rst) begin
      lock_cnt   <= 0;
      pll_locked <= 1'b0;
    end else if (lock_cnt < 6) lock_cnt <= lock_cnt + 1;
    else pll_locked <= 1'b1;
    if (pll_step) steps_seen <= steps_seen + 1;
  end

  always @(negedge clk) if (pll_rst) rst_hi <= rst_hi + 1;

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic wait_idle();
    int s;
    for (int i = 0; i < 2000; i++) begin
      rd(2, s);
      if ((s & 1) == 0) break;
    end
  endtask

  task automatic t_reset_state();
    int v;
    check("R1 pll_step", pll_step, 0);
    check("R1 pll_rst", pll_rst, 0);
    check("R1 pll_dir", pll_dir, 0);
    check("R1 pll_clksel", pll_clksel, 0);
    check("R1 phase_acc", phase_acc, 0);
    rd(0, v); check("R1 cmd readback", v, 0);
    rd(1, v); check("R1 count readback", v, 0);
    rd(2, v); check("R1 busy", v & 1, 0);
  endtask

  task automatic t_registers();
    int v;
    wr(1, 16'hBEEF); rd(1, v); check("R6 count readback", v, 16'hBEEF);
    wr(1, 0);
    wr(0, 4'h7);   // go with count 0, direction 1, independent clock
    check("R8 no step", pll_step, 0);
    rd(2, v); check("R8 busy low", v & 1, 0);
    rd(0, v); check("R5 go reads 0", v, 4'h6);
    check("R4 clksel pin", pll_clksel, 1);
    wr(0, 4'h0); rd(0, v); check("R4 clksel cleared", v, 0);
    check("R4 clksel pin low", pll_clksel, 0);
    wr(0, 4'h4); check("R4 clksel set alone", pll_clksel, 1);
    rd(2, v); check("R7 lock bit", (v >> 1) & 1, 1);
    wr(0, 0);
  endtask

  task automatic t_handshake();
    int v;
    auto_done = 1'b0;
    wr(1, 2);
    wr(0, 1);
    check("R2 first step after write", pll_step, 1);
    check("R3 forward dir", pll_dir, 0);
    @(negedge clk); check("R2 step one cycle", pll_step, 0);
    repeat (3) @(negedge clk);
    check("R2 no step before done", pll_step, 0);
    check("R12 acc waits for done", phase_acc, exp_acc);
    man_done = 1'b1; @(negedge clk); man_done = 1'b0;
    exp_acc++;
    check("R2 step after done", pll_step, 1);
    check("R3 acc +1", phase_acc, exp_acc);
    @(negedge clk);
    man_done = 1'b1; @(negedge clk); man_done = 1'b0;
    exp_acc++;
    check("R2 no step after last", pll_step, 0);
    check("R3 acc +2", phase_acc, exp_acc);
    rd(2, v); check("R7 busy falls after last done", v & 1, 0);
    man_done = 1'b1; @(negedge clk); man_done = 1'b0;
    @(negedge clk);
    check("R12 idle done ignored", phase_acc, exp_acc);
    rd(2, v); check("R12 idle done busy", v & 1, 0);
    auto_done = 1'b1;
  endtask

  task automatic t_runs();
    int v, s0;
    s0 = steps_seen;
    wr(1, 5); wr(0, 1);
    rd(2, v); check("R7 busy during run", v, 3);
    wait_idle();
    exp_acc += 5;
    check("R2 five steps", steps_seen - s0, 5);
    check("R3 forward total", phase_acc, exp_acc);
    s0 = steps_seen;
    wr(1, 3); wr(0, 2'b11);
    check("R3 backward dir pin", pll_dir, 1);
    wait_idle();
    exp_acc -= 3;
    check("R3 backward total", phase_acc, exp_acc);
    check("R2 three steps", steps_seen - s0, 3);
    s0 = steps_seen;
    wr(1, 4); wr(0, 1);
    wr(1, 9); wr(0, 2'b11);   // second go during the run
    check("R9 dir unchanged", pll_dir, 0);
    wait_idle();
    repeat (8) @(negedge clk);
    exp_acc += 4;
    check("R9 steps of first go", steps_seen - s0, 4);
    check("R9 acc of first go", phase_acc, exp_acc);
  endtask

  task automatic t_abort();
    int v, s0;
    wr(1, 50); wr(0, 1);
    repeat (10) @(negedge clk);
    rst_hi = 0;
    wr(0, 4'b1001);   // reset with go in the same write
    exp_acc = 0;
    check("R10 pll_rst high", pll_rst, 1);
    check("R10 acc zero", phase_acc, 0);
    s0 = steps_seen;
    wr(0, 1);          // go while in reset
    rd(2, v); check("R10 busy cleared", v & 1, 0);
    repeat (RSTC + 2) @(negedge clk);
    check("R10 reset width", rst_hi, RSTC);
    rd(2, v); check("R11 lock low after reset", v, 0);
    wr(0, 1);          // go while unlocked
    repeat (20) @(negedge clk);
    check("R11 refused go", steps_seen - s0, 0);
    check("R12 late done ignored", phase_acc, 0);
    wr(1, 2); wr(0, 1);
    wait_idle();
    exp_acc = 2;
    check("R11 go after lock", phase_acc, exp_acc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    repeat (10) @(negedge clk);
    t_registers();
    t_handshake();
    t_runs();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule